// File: doc/BRIEF.md
# Four-State Add-Compare-Select with Approximate Minimum

This block performs one trellis step of a Viterbi decoder whose trellis has four states, each reached from all four states. For every destination state it adds each source state's stored path metric to the branch metric of the connecting transition. It then chooses a winner among the four sums. Metrics are kept per state and updated together once per step. The block reports the winning source index of each state as a survivor for an external traceback.

The winner is not found by a full comparator tree. The four sums are OR-ed together and the position of the leading one is derived with a running OR and a ones count. Only one bit column of the four sums is then inspected, and a small priority table turns that 4-bit column into a 2-bit index. The result is cheap and shallow, but it can pick a sum that is not the smallest. A normalization stage lowers every metric by a fixed amount when all of them sit above that amount, so the registers do not climb without bound. A frame-start strobe loads the initial metrics, which favour state 0.

Top module: `acs4_unit`

## Requirements
- R1: The candidate for destination state s from source state c is the stored metric of c plus branch metric `bm_flat[(s*4+c)*BMW +: BMW]`, saturated to the all-ones PMW-bit value (0x7FF for PMW=11).
- R2: The inspected bit position comes from the OR of the four candidates of a state. Let k be the number of ones in the running OR taken from the MSB down, which is the leading-one index plus 1, or 0 when the OR is zero. The position is k-1 for k from 1 to 7, bit 6 for k of 8 or more, and bit 0 for k of 0.
- R3: The winner is the lowest-index candidate whose inspected bit is 0, or candidate 0 when all four bits are 1. Its value becomes the new metric and its index appears on `surv_flat[2*s +: 2]`.
- R4: When all four new metrics are strictly greater than NORM_C (64), NORM_C is subtracted from each. Otherwise they are stored unchanged.
- R5: With `step_en` high at a rising edge, the metrics and survivors update at that edge and `surv_vld` is high for the following cycle only.
- R6: `frame_start` at an edge loads metric 0 into state 0 and 0x3FF into states 1 to 3, and clears the survivors. It wins over `step_en` in the same cycle.
- R7: In a cycle with neither strobe, the metrics and survivors hold their values.
- R8: While reset is asserted, the metrics hold the frame-start values, the survivors are 0 and `surv_vld` is 0.
- R9: All four states compute from the metrics stored before the step, with no state seeing another state's new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Load initial metrics for a new frame |
| step_en | input | 1 | Perform one trellis step this cycle |
| bm_flat | input | 16*BMW | Branch metrics, entry (s*4+c) for source c into state s |
| pm_flat | output | 4*PMW | Stored path metrics, state s at bits s*PMW |
| surv_flat | output | 8 | Survivor source index per state, state s at bits 2*s |
| surv_vld | output | 1 | Survivors are from a step taken on the last edge |

## Verification
The bench builds the block with PMW=11, BMW=10 and NORM_C=64. A 10-bit branch metric can push the best metric up by far more than 64 per step, so a few steps of large metrics drive every candidate into saturation, and normalization then works on saturated values. The 11-bit metrics with a 0x3FF start value also give leading-one positions above 8, so the capped bit-6 column is exercised. Small branch metrics bring in low positions where the approximate pick visibly differs from the true minimum.

// File: rtl/acs4_pkg.sv
package acs4_pkg;
  localparam int NSTATE = 4;
  localparam int SEL_W  = 2;
endpackage

// File: rtl/acs4_cand_add.sv
module acs4_cand_add #(
  parameter int PMW = 11,
  parameter int BMW = 10
) (
  input  logic [PMW-1:0] pm_in,
  input  logic [BMW-1:0] bm_in,
  output logic [PMW-1:0] sum_out
);
  localparam int WW = PMW + 1;
  logic [WW-1:0] wide;

  always_comb begin
    wide    = {1'b0, pm_in} + WW'(bm_in);
    sum_out = wide[PMW] ? {PMW{1'b1}} : wide[PMW-1:0];
  end
endmodule

// File: rtl/acs4_pick_min.sv
module acs4_pick_min
  import acs4_pkg::*;
#(
  parameter int PMW     = 11,
  parameter int CAP_K   = 8,
  parameter int CAP_BIT = 6
) (
  input  logic [NSTATE*PMW-1:0] cand_flat,
  output logic [SEL_W-1:0]      sel,
  output logic [PMW-1:0]        win
);
  localparam int CW = $clog2(PMW + 1);
  localparam int PW = $clog2(PMW);

  logic [PMW-1:0]    or_vec;
  logic [PMW-1:0]    run;
  logic [CW-1:0]     k;
  logic [PW-1:0]     pos;
  logic [NSTATE-1:0] col;

  always_comb begin
    or_vec = '0;
    for (int c = 0; c < NSTATE; c++) begin
      or_vec = or_vec | cand_flat[c*PMW +: PMW];
    end
  end

  generate
    for (genvar i = 0; i < PMW; i++) begin : g_run
      if (i == PMW - 1) begin : g_top
        assign run[i] = or_vec[i];
      end else begin : g_low
        assign run[i] = run[i+1] | or_vec[i];
      end
    end
  endgenerate

  always_comb begin
    k = CW'($countones(run));
    if (k == '0) begin
      pos = '0;
    end else if (k >= CW'(CAP_K)) begin
      pos = PW'(CAP_BIT);
    end else begin
      pos = PW'(k - CW'(1));
    end
  end

  generate
    for (genvar c = 0; c < NSTATE; c++) begin : g_col
      assign col[c] = cand_flat[c*PMW + int'(pos)];
    end
  endgenerate

  always_comb begin
    casez (col)
      4'b???0: sel = 2'd0;
      4'b??01: sel = 2'd1;
      4'b?011: sel = 2'd2;
      4'b0111: sel = 2'd3;
      default: sel = 2'd0;
    endcase
    win = cand_flat[int'(sel)*PMW +: PMW];
  end
endmodule

// File: rtl/acs4_norm.sv
module acs4_norm
  import acs4_pkg::*;
#(
  parameter int PMW    = 11,
  parameter int NORM_C = 64
) (
  input  logic [NSTATE*PMW-1:0] raw_flat,
  output logic [NSTATE*PMW-1:0] adj_flat
);
  logic [NSTATE-1:0] above;

  generate
    for (genvar s = 0; s < NSTATE; s++) begin : g_cmp
      assign above[s] = raw_flat[s*PMW +: PMW] > PMW'(NORM_C);
      assign adj_flat[s*PMW +: PMW] = (&above) ?
        raw_flat[s*PMW +: PMW] - PMW'(NORM_C) : raw_flat[s*PMW +: PMW];
    end
  endgenerate
endmodule

// File: rtl/acs4_unit.sv
module acs4_unit
  import acs4_pkg::*;
#(
  parameter int PMW    = 11,
  parameter int BMW    = 10,
  parameter int NORM_C = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_start,
  input  logic                          step_en,
  input  logic [NSTATE*NSTATE*BMW-1:0]  bm_flat,
  output logic [NSTATE*PMW-1:0]         pm_flat,
  output logic [NSTATE*SEL_W-1:0]       surv_flat,
  output logic                          surv_vld
);
  localparam logic [PMW-1:0] START_HI = {1'b0, {(PMW-1){1'b1}}};

  logic [1:0]                rst_pipe;
  logic                      rst_sync_n;
  logic [NSTATE*PMW-1:0]     pm_q, pm_d, pm_init;
  logic [NSTATE*SEL_W-1:0]   sv_q, sv_d;
  logic                      vld_q, vld_d;
  logic                      upd_en;
  logic [NSTATE*PMW-1:0]     best_flat, norm_flat;
  logic [NSTATE*SEL_W-1:0]   sel_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  generate
    for (genvar s = 0; s < NSTATE; s++) begin : g_init
      assign pm_init[s*PMW +: PMW] = (s == 0) ? '0 : START_HI;
    end

    for (genvar s = 0; s < NSTATE; s++) begin : g_state
      logic [NSTATE*PMW-1:0] cand;
      for (genvar c = 0; c < NSTATE; c++) begin : g_src
        acs4_cand_add #(.PMW(PMW), .BMW(BMW)) u_add (
          .pm_in  (pm_q[c*PMW +: PMW]),
          .bm_in  (bm_flat[(s*NSTATE+c)*BMW +: BMW]),
          .sum_out(cand[c*PMW +: PMW])
        );
      end
      acs4_pick_min #(.PMW(PMW)) u_pick (
        .cand_flat(cand),
        .sel      (sel_flat[s*SEL_W +: SEL_W]),
        .win      (best_flat[s*PMW +: PMW])
      );
    end
  endgenerate

  acs4_norm #(.PMW(PMW), .NORM_C(NORM_C)) u_norm (
    .raw_flat(best_flat),
    .adj_flat(norm_flat)
  );

  always_comb begin
    pm_d  = pm_q;
    sv_d  = sv_q;
    vld_d = 1'b0;
    if (frame_start) begin
      pm_d = pm_init;
      sv_d = '0;
    end else if (step_en) begin
      pm_d  = norm_flat;
      sv_d  = sel_flat;
      vld_d = 1'b1;
    end
  end

  assign upd_en = frame_start | step_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pm_q <= pm_init;
      sv_q <= '0;
    end else if (upd_en) begin
      pm_q <= pm_d;
      sv_q <= sv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign pm_flat   = pm_q;
  assign surv_flat = sv_q;
  assign surv_vld  = vld_q;
endmodule

// File: rtl/acs4_unit_chk.sv
module acs4_unit_chk
  import acs4_pkg::*;
#(
  parameter int PMW    = 11,
  parameter int BMW    = 10,
  parameter int NORM_C = 64
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          frame_start,
  input logic                          step_en,
  input logic [NSTATE*NSTATE*BMW-1:0]  bm_flat,
  input logic [NSTATE*PMW-1:0]         pm_flat,
  input logic [NSTATE*SEL_W-1:0]       surv_flat,
  input logic                          surv_vld
);
  localparam logic [PMW-1:0] START_HI = {1'b0, {(PMW-1){1'b1}}};

  function automatic logic [PMW-1:0] cand_of(
    input logic [NSTATE*PMW-1:0]        pv,
    input logic [NSTATE*NSTATE*BMW-1:0] bv,
    input int                           s,
    input logic [SEL_W-1:0]             c);
    logic [PMW:0] w;
    w = {1'b0, pv[int'(c)*PMW +: PMW]} + (PMW+1)'(bv[(s*NSTATE+int'(c))*BMW +: BMW]);
    return w[PMW] ? {PMW{1'b1}} : w[PMW-1:0];
  endfunction

  // R6: frame start loads the start metrics and clears survivors
  a_r6_frame_init: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (pm_flat == {START_HI, START_HI, START_HI, {PMW{1'b0}}}) && (surv_flat == '0));

  // R7: no strobe, nothing moves
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !step_en) |=> ($stable(pm_flat) && $stable(surv_flat)));

  // R5: survivor valid follows an accepted step
  a_r5_vld_set: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !frame_start) |=> surv_vld);

  a_r5_vld_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en || frame_start) |=> !surv_vld);

  // R3/R4: the stored metric is the chosen candidate, possibly lowered by NORM_C
  generate
    for (genvar g = 0; g < NSTATE; g++) begin : g_st
      a_r3_metric_match: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !frame_start) |=>
          ((pm_flat[g*PMW +: PMW] == cand_of($past(pm_flat), $past(bm_flat), g, surv_flat[g*SEL_W +: SEL_W])) ||
           (pm_flat[g*PMW +: PMW] == cand_of($past(pm_flat), $past(bm_flat), g, surv_flat[g*SEL_W +: SEL_W]) - PMW'(NORM_C))));
    end
  endgenerate
endmodule

bind acs4_unit acs4_unit_chk #(.PMW(PMW), .BMW(BMW), .NORM_C(NORM_C)) u_chk (.*);

// File: tb/acs4_unit_bench.sv
module acs4_unit_bench;
  localparam int PMW = 11;
  localparam int BMW = 10;
  localparam int NC  = 64;
  localparam int NBM = 16 * BMW;

  logic           clk;
  logic           rst_n;
  logic           frame_start;
  logic           step_en;
  logic [NBM-1:0] bm_flat;
  logic [4*PMW-1:0] pm_flat;
  logic [7:0]     surv_flat;
  logic           surv_vld;

  int checks;
  int failures;
  logic [PMW-1:0] m_pm [4];
  logic [1:0]     m_sv [4];

  acs4_unit #(.PMW(PMW), .BMW(BMW), .NORM_C(NC)) u_acs4_unit (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .step_en(step_en),
    .bm_flat(bm_flat), .pm_flat(pm_flat), .surv_flat(surv_flat), .surv_vld(surv_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [PMW-1:0] ref_add(input logic [PMW-1:0] p, input logic [BMW-1:0] b);
    logic [PMW:0] w;
    w = {1'b0, p} + (PMW+1)'(b);
    return w[PMW] ? {PMW{1'b1}} : w[PMW-1:0];
  endfunction

  task automatic model_init();
    m_pm[0] = '0;
    for (int s = 1; s < 4; s++) m_pm[s] = 11'h3FF;
    for (int s = 0; s < 4; s++) m_sv[s] = 2'd0;
  endtask

  task automatic model_step(input logic [NBM-1:0] bm);
    logic [PMW-1:0] nv [4];
    logic [PMW-1:0] cd [4];
    logic [PMW-1:0] orv;
    int msb, k, pos, sel;
    bit found, all_gt;
    for (int s = 0; s < 4; s++) begin
      orv = '0;
      for (int c = 0; c < 4; c++) begin
        cd[c] = ref_add(m_pm[c], bm[(s*4+c)*BMW +: BMW]);
        orv = orv | cd[c];
      end
      msb = -1;
      for (int i = 0; i < PMW; i++) if (orv[i]) msb = i;
      k = msb + 1;
      pos = (k == 0) ? 0 : ((k >= 8) ? 6 : k - 1);
      sel = 0; found = 0;
      for (int c = 0; c < 4; c++) begin
        if (!found && !cd[c][pos]) begin sel = c; found = 1; end
      end
      nv[s] = cd[sel];
      m_sv[s] = 2'(sel);
    end
    all_gt = 1;
    for (int s = 0; s < 4; s++) if (nv[s] <= PMW'(NC)) all_gt = 0;
    for (int s = 0; s < 4; s++) m_pm[s] = all_gt ? nv[s] - PMW'(NC) : nv[s];
  endtask

  task automatic check_all(input string req);
    logic [4*PMW-1:0] ep;
    logic [7:0] es;
    for (int s = 0; s < 4; s++) begin
      ep[s*PMW +: PMW] = m_pm[s];
      es[s*2 +: 2] = m_sv[s];
    end
    checks++;
    if (pm_flat !== ep || surv_flat !== es) begin
      failures++;
      $display("FAIL %s pm=%h surv=%h expected pm=%h surv=%h", req, pm_flat, surv_flat, ep, es);
    end
  endtask

  task automatic check_vld(input logic exp, input string req);
    checks++;
    if (surv_vld !== exp) begin
      failures++;
      $display("FAIL %s surv_vld=%b expected=%b", req, surv_vld, exp);
    end
  endtask

  task automatic apply(input logic fs, input logic st, input logic [NBM-1:0] bm);
    @(negedge clk);
    frame_start = fs; step_en = st; bm_flat = bm;
    @(posedge clk);
    #1;
    frame_start = 1'b0; step_en = 1'b0;
    if (fs) model_init();
    else if (st) model_step(bm);
  endtask

  function automatic logic [NBM-1:0] all_bm(input logic [BMW-1:0] v);
    logic [NBM-1:0] r;
    for (int i = 0; i < 16; i++) r[i*BMW +: BMW] = v;
    return r;
  endfunction

  function automatic logic [NBM-1:0] bm_of(input int s, input int c, input logic [BMW-1:0] v,
                                            input logic [NBM-1:0] base);
    logic [NBM-1:0] r;
    r = base;
    r[(s*4+c)*BMW +: BMW] = v;
    return r;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired expected run to complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [NBM-1:0] bm;
    checks = 0; failures = 0;
    void'($urandom(32'd5151));
    rst_n = 1'b0; frame_start = 1'b0; step_en = 1'b0; bm_flat = '0;
    model_init();
    repeat (3) @(posedge clk);
    #1;
    check_all("R8 reset metrics"); check_vld(1'b0, "R8 reset valid");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R8 after release");

    // R9: all states see the previous metrics; zero branch metrics pick source 0
    apply(1'b0, 1'b1, '0);
    check_all("R9 first step"); check_vld(1'b1, "R5 valid after step");
    apply(1'b0, 1'b0, all_bm(10'd77));
    check_all("R7 hold"); check_vld(1'b0, "R5 valid drops");

    // R2/R3: approximate picks with metrics all zero
    bm = '0;
    bm = bm_of(0,0,10'd5,bm); bm = bm_of(0,1,10'd4,bm); bm = bm_of(0,2,10'd6,bm); bm = bm_of(0,3,10'd7,bm);
    bm = bm_of(1,0,10'd3,bm); bm = bm_of(1,1,10'd2,bm); bm = bm_of(1,2,10'd1,bm); bm = bm_of(1,3,10'd0,bm);
    bm = bm_of(2,0,10'd9,bm); bm = bm_of(2,1,10'd8,bm); bm = bm_of(2,2,10'd2,bm); bm = bm_of(2,3,10'd1,bm);
    apply(1'b0, 1'b1, bm);
    check_all("R2 R3 approximate column pick");
    checks++;
    if (surv_flat !== 8'b00_10_10_00) begin
      failures++;
      $display("FAIL R3 surv=%b expected=%b", surv_flat, 8'b00_10_10_00);
    end

    // R4: boundary 64 not normalized, 65 normalized
    apply(1'b1, 1'b0, '0); apply(1'b0, 1'b1, '0);
    apply(1'b0, 1'b1, all_bm(10'd64));
    check_all("R4 equal to constant kept");
    apply(1'b1, 1'b0, '0); apply(1'b0, 1'b1, '0);
    apply(1'b0, 1'b1, all_bm(10'd65));
    check_all("R4 above constant lowered");

    // R1: saturation with large branch metrics
    for (int i = 0; i < 4; i++) apply(1'b0, 1'b1, all_bm(10'h3FF));
    check_all("R1 saturated metrics");

    // R6: frame start wins over step
    apply(1'b1, 1'b1, all_bm(10'd9));
    check_all("R6 frame start priority"); check_vld(1'b0, "R6 no valid on frame start");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r, sh;
      r = $urandom_range(0, 19);
      sh = $urandom_range(0, 9);
      for (int i = 0; i < 16; i++) bm[i*BMW +: BMW] = BMW'($urandom) >> sh;
      if (r == 0) begin
        apply(1'b1, 1'($urandom_range(0,1)), bm);
        check_all("R6 random frame start");
      end else if (r < 4) begin
        apply(1'b0, 1'b0, bm);
        check_all("R7 random idle"); check_vld(1'b0, "R5 random idle valid");
      end else begin
        apply(1'b0, 1'b1, bm);
        check_all("R1 R2 R3 R4 random step"); check_vld(1'b1, "R5 random valid");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule